// File: doc/BRIEF.md
# Security-Tagged Direct-Mapped Cache Tag Lookup

This block holds the tag store and hit logic of a direct-mapped cache shared by a secure and a normal execution world. Every resident line remembers the non-secure (NS) attribute of the transaction that filled it. That attribute is compared together with the address tag. The same physical address can therefore exist once as a secure line and once as a non-secure line, and the two never alias. A change of world needs no flush. The data array, refill, write-back and coherency sit outside this block.

A lookup presents an address, an NS bit and the world that issued it. The result appears one clock later as hit, miss and the hit set index. An allocate request installs a tag with its NS attribute. Each world has its own cache enable. An invalidate command clears either every line or only the lines whose NS attribute matches a given value.

Top module: `sec_tag_cache`

## Requirements
- R1: An address splits into byte offset bits [3:0], set index bits [7:4] and tag bits [31:8] across 16 sets. A lookup hits only when the indexed line is valid, its stored tag equals the address tag, and its stored NS attribute equals the effective NS bit of the lookup.
- R2: A lookup with effective NS=1 never hits a line stored with NS=0, even when the tags are equal.
- R3: Lines with NS=0 and NS=1 are resident at once in different sets. Alternating lookups between the two worlds leaves all of them valid.
- R4: A secure-world allocate issued with NS=1 stores a non-secure line, and later normal-world lookups of that address hit it.
- R5: Any access from the normal world uses effective NS=1 whatever its NS input. A secure-world access uses its NS input as given.
- R6: The cache enables of the secure and normal worlds are separate. A lookup from a world whose enable is low always misses. An allocate from such a world changes no line.
- R7: An allocate always replaces the line in its set and rewrites that line's tag and NS attribute, whatever the line held before.
- R8: A global invalidate (inv_valid=1, inv_by_ns=0) clears every valid bit in a single cycle.
- R9: A qualified invalidate (inv_valid=1, inv_by_ns=1) clears only the lines whose stored NS equals inv_ns.
- R10: Results are registered. res_valid is high exactly one cycle after a lookup request, and res_hit and res_miss are never high together. res_index carries the looked-up set on a hit and 0 otherwise. After reset no line is valid and res_valid is low.
- R11: A lookup sees the array as it stood before the updates of its own cycle. When an allocate and an invalidate occur in the same cycle, the invalidate is applied first, so the allocated line stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_secure | input | 1 | Cache enable for the secure world |
| en_normal | input | 1 | Cache enable for the normal world |
| lk_valid | input | 1 | Lookup request |
| lk_secure_world | input | 1 | Lookup issued by the secure world |
| lk_ns | input | 1 | NS bit of the lookup |
| lk_addr | input | 32 | Lookup address |
| alloc_valid | input | 1 | Allocate request |
| alloc_secure_world | input | 1 | Allocate issued by the secure world |
| alloc_ns | input | 1 | NS bit of the allocate |
| alloc_addr | input | 32 | Allocate address |
| inv_valid | input | 1 | Invalidate command |
| inv_by_ns | input | 1 | 1: clear only lines whose NS matches inv_ns; 0: clear all |
| inv_ns | input | 1 | NS value selected by a qualified invalidate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup hit |
| res_miss | output | 1 | Lookup miss |
| res_index | output | 4 | Set index of the hit line |

## Verification
Three activities can land in the same cycle: a lookup, an allocate and an invalidate. The bench drives a lookup and an allocate of the same address in one cycle and expects a miss, then a hit on the next lookup. It also drives a global invalidate together with an allocate and expects only the newly allocated set to survive a sweep of all sets. A reference array in the bench applies the invalidate before the allocate and judges every registered lookup against that array, covering both worlds and both NS values.

// File: rtl/sct_pkg.sv
package sct_pkg;

  // Effective NS attribute of an access: the normal world is always non-secure.
  function automatic logic eff_ns(input logic secure_world, input logic ns_in);
    return secure_world ? ns_in : 1'b1;
  endfunction

  // Enable that governs an access from the given world.
  function automatic logic world_en(input logic secure_world,
                                    input logic en_sec, input logic en_nrm);
    return secure_world ? en_sec : en_nrm;
  endfunction

  // Line match: valid, equal tag and equal NS attribute.
  function automatic logic line_match(input logic valid, input logic stored_ns,
                                      input logic req_ns, input logic tag_eq);
    return valid && tag_eq && (stored_ns == req_ns);
  endfunction

  // Whether an invalidate command clears a line with the given NS attribute.
  function automatic logic inv_hits(input logic inv_en, input logic by_ns,
                                    input logic sel_ns, input logic line_ns);
    return inv_en && (!by_ns || (line_ns == sel_ns));
  endfunction

endpackage

// File: rtl/sct_tag_array.sv
module sct_tag_array #(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_ns,
  input  logic             inv_en,
  input  logic             inv_by_ns,
  input  logic             inv_ns,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_ns,
  output logic [TAG_W-1:0] rd_tag,
  output logic [SETS-1:0]  valid_vec
);

  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  ns_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ns_q    <= '0;
      for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (wr_en && (wr_idx == IDX_W'(s))) begin
          valid_q[s] <= 1'b1;
          ns_q[s]    <= wr_ns;
          tag_q[s]   <= wr_tag;
        end else if (sct_pkg::inv_hits(inv_en, inv_by_ns, inv_ns, ns_q[s])) begin
          valid_q[s] <= 1'b0;
        end
      end
    end
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_ns     = ns_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign valid_vec = valid_q;

endmodule

// File: rtl/sct_compare.sv
module sct_compare #(
  parameter int TAG_W = 24
) (
  input  logic             req_en,
  input  logic             req_ns,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             line_valid,
  input  logic             line_ns,
  input  logic [TAG_W-1:0] line_tag,
  output logic             hit
);

  logic tag_eq;
  assign tag_eq = (req_tag == line_tag);
  assign hit    = req_en && sct_pkg::line_match(line_valid, line_ns, req_ns, tag_eq);

endmodule

// File: rtl/sec_tag_cache.sv
module sec_tag_cache #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 4,
  parameter int SETS     = 16,
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - IDX_W - OFFSET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_secure,
  input  logic              en_normal,
  input  logic              lk_valid,
  input  logic              lk_secure_world,
  input  logic              lk_ns,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              alloc_valid,
  input  logic              alloc_secure_world,
  input  logic              alloc_ns,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              inv_valid,
  input  logic              inv_by_ns,
  input  logic              inv_ns,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic [IDX_W-1:0]  res_index
);

  // Address fields
  logic [IDX_W-1:0] lk_idx, alloc_idx;
  logic [TAG_W-1:0] lk_tag, alloc_tag;
  assign lk_idx    = lk_addr[OFFSET_W +: IDX_W];
  assign lk_tag    = lk_addr[ADDR_W-1 -: TAG_W];
  assign alloc_idx = alloc_addr[OFFSET_W +: IDX_W];
  assign alloc_tag = alloc_addr[ADDR_W-1 -: TAG_W];

  logic unused_offsets;
  assign unused_offsets = ^{lk_addr[OFFSET_W-1:0], alloc_addr[OFFSET_W-1:0]};

  // Named internal events
  logic lk_eff_ns, lk_enabled, alloc_eff_ns, alloc_enabled, alloc_fire, hit_now;
  assign lk_eff_ns     = sct_pkg::eff_ns(lk_secure_world, lk_ns);
  assign lk_enabled    = sct_pkg::world_en(lk_secure_world, en_secure, en_normal);
  assign alloc_eff_ns  = sct_pkg::eff_ns(alloc_secure_world, alloc_ns);
  assign alloc_enabled = sct_pkg::world_en(alloc_secure_world, en_secure, en_normal);
  assign alloc_fire    = alloc_valid && alloc_enabled;

  logic             rd_valid, rd_ns;
  logic [TAG_W-1:0] rd_tag;
  logic [SETS-1:0]  valid_vec;

  sct_tag_array #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (alloc_fire),
    .wr_idx    (alloc_idx),
    .wr_tag    (alloc_tag),
    .wr_ns     (alloc_eff_ns),
    .inv_en    (inv_valid),
    .inv_by_ns (inv_by_ns),
    .inv_ns    (inv_ns),
    .rd_idx    (lk_idx),
    .rd_valid  (rd_valid),
    .rd_ns     (rd_ns),
    .rd_tag    (rd_tag),
    .valid_vec (valid_vec)
  );

  sct_compare #(.TAG_W(TAG_W)) u_cmp (
    .req_en     (lk_valid && lk_enabled),
    .req_ns     (lk_eff_ns),
    .req_tag    (lk_tag),
    .line_valid (rd_valid),
    .line_ns    (rd_ns),
    .line_tag   (rd_tag),
    .hit        (hit_now)
  );

  // Registered result stage
  logic             res_valid_q, res_hit_q;
  logic [IDX_W-1:0] res_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_hit_q   <= 1'b0;
      res_idx_q   <= '0;
    end else begin
      res_valid_q <= lk_valid;
      res_hit_q   <= hit_now;
      res_idx_q   <= hit_now ? lk_idx : '0;
    end
  end

  assign res_valid = res_valid_q;
  assign res_hit   = res_hit_q;
  assign res_miss  = res_valid_q && !res_hit_q;
  assign res_index = res_idx_q;

endmodule

// File: rtl/sct_checker.sv
module sct_checker #(
  parameter int SETS  = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_secure_world,
  input logic             lk_enabled,
  input logic             hit_now,
  input logic             rd_ns,
  input logic             alloc_fire,
  input logic [IDX_W-1:0] alloc_idx,
  input logic             inv_valid,
  input logic             inv_by_ns,
  input logic [SETS-1:0]  valid_vec,
  input logic             res_valid,
  input logic             res_hit,
  input logic             res_miss
);

  // R10: result follows a request by one cycle
  a_r10_result_latency: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  a_r10_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_hit && res_miss));

  // R6: disabled world never hits
  a_r6_disabled_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_enabled) |=> !res_hit);
  // R6: no allocate and no invalidate leave the valid bits untouched
  a_r6_state_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_fire && !inv_valid) |=> $stable(valid_vec));

  // R5 and R2: a normal-world hit is only ever on a non-secure line
  a_r5_normal_hits_ns_line: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_secure_world && hit_now) |-> rd_ns);

  // R7 and R11: an allocated set is valid afterwards, even with invalidate
  a_r7_alloc_lands: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> valid_vec[$past(alloc_idx)]);

  // R8: global invalidate empties the array in one cycle
  a_r8_global_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_by_ns && !alloc_fire) |=> (valid_vec == '0));

endmodule

bind sec_tag_cache sct_checker #(.SETS(SETS), .IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .lk_valid        (lk_valid),
  .lk_secure_world (lk_secure_world),
  .lk_enabled      (lk_enabled),
  .hit_now         (hit_now),
  .rd_ns           (rd_ns),
  .alloc_fire      (alloc_fire),
  .alloc_idx       (alloc_idx),
  .inv_valid       (inv_valid),
  .inv_by_ns       (inv_by_ns),
  .valid_vec       (valid_vec),
  .res_valid       (res_valid),
  .res_hit         (res_hit),
  .res_miss        (res_miss)
);

// File: tb/sim_sec_tag_cache.sv
module sim_sec_tag_cache;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, en_s, en_n;
  logic lv, lsw, lns, av, asw, ans, iv, iq, ins;
  logic [31:0] la, aa;
  logic res_valid, res_hit, res_miss;
  logic [3:0] res_index;

  sec_tag_cache u0 (
    .clk(clk), .rst_n(rst_n), .en_secure(en_s), .en_normal(en_n),
    .lk_valid(lv), .lk_secure_world(lsw), .lk_ns(lns), .lk_addr(la),
    .alloc_valid(av), .alloc_secure_world(asw), .alloc_ns(ans), .alloc_addr(aa),
    .inv_valid(iv), .inv_by_ns(iq), .inv_ns(ins),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss), .res_index(res_index)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference array built from the requirements
  bit        mv [16];
  bit        mns[16];
  bit [23:0] mtag[16];

  function automatic logic [31:0] mk(input logic [23:0] t, input int s);
    return {t, 4'(s), 4'h9};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, result judged at the following negedge
  task automatic cyc(input bit l_v, input bit l_sw, input bit l_ns, input logic [31:0] l_a,
                     input bit a_v, input bit a_sw, input bit a_ns, input logic [31:0] a_a,
                     input bit i_v, input bit i_q, input bit i_ns, input string req);
    int  ix = int'(l_a[7:4]);
    bit  len = l_sw ? en_s : en_n;
    bit  lef = l_sw ? l_ns : 1'b1;
    bit  ehit = l_v && len && mv[ix] && (mtag[ix] == l_a[31:8]) && (mns[ix] == lef);
    int  ai = int'(a_a[7:4]);
    bit  aen = a_sw ? en_s : en_n;
    lv = l_v; lsw = l_sw; lns = l_ns; la = l_a;
    av = a_v; asw = a_sw; ans = a_ns; aa = a_a;
    iv = i_v; iq = i_q; ins = i_ns;
    // R11: invalidate first, then allocate
    for (int s = 0; s < 16; s++)
      if (i_v && (!i_q || mns[s] == i_ns)) mv[s] = 0;
    if (a_v && aen) begin
      mv[ai] = 1; mtag[ai] = a_a[31:8]; mns[ai] = a_sw ? a_ns : 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    lv = 0; av = 0; iv = 0;
    chk(res_valid == l_v, req, "res_valid", int'(res_valid), int'(l_v));
    if (l_v) begin
      chk(res_hit == ehit && res_miss == !ehit, req, "hit", int'(res_hit), int'(ehit));
      chk(res_index == (ehit ? 4'(ix) : 4'd0), req, "index", int'(res_index),
          ehit ? ix : 0);
    end
  endtask

  task automatic look(input bit sw, input bit ns, input logic [31:0] a, input string req);
    cyc(1, sw, ns, a, 0, 0, 0, 32'h0, 0, 0, 0, req);
  endtask

  task automatic fill(input bit sw, input bit ns, input logic [31:0] a, input string req);
    cyc(0, 0, 0, 32'h0, 1, sw, ns, a, 0, 0, 0, req);
  endtask

  task automatic sweep(input logic [23:0] tb, input string req);
    for (int s = 0; s < 16; s++) begin
      look(1, 0, mk(tb + 24'(s), s), req);
      look(0, 0, mk(tb + 24'(s), s), req);
      look(1, 1, mk(tb + 24'(s), s), req);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en_s = 1; en_n = 1;
    lv = 0; lsw = 0; lns = 0; la = 0; av = 0; asw = 0; ans = 0; aa = 0;
    iv = 0; iq = 0; ins = 0;
    for (int s = 0; s < 16; s++) begin mv[s] = 0; mns[s] = 0; mtag[s] = 0; end
    repeat (3) @(negedge clk);
    chk(res_valid == 0 && res_hit == 0, "R10", "reset outputs", int'(res_valid), 0);
    rst_n = 1;
    @(negedge clk);
    sweep(24'h100, "R1");                         // empty after reset

    // R3: even sets secure (NS=0), odd sets from the normal world
    for (int s = 0; s < 16; s++) fill(s % 2 == 0, 0, mk(24'h100 + 24'(s), s), "R3");
    for (int s = 0; s < 16; s++) begin
      look(1, 0, mk(24'h100 + 24'(s), s), "R1");  // alternate worlds each cycle
      look(0, 1, mk(24'h100 + 24'(s), s), "R2");
    end
    sweep(24'h100, "R3");
    look(1, 0, mk(24'h777, 2), "R1");             // tag mismatch

    fill(1, 1, mk(24'hABC, 3), "R4");              // secure world, NS=1
    look(0, 0, mk(24'hABC, 3), "R4");
    look(1, 0, mk(24'hABC, 3), "R4");
    fill(0, 0, mk(24'h5A5, 5), "R5");              // normal world forced NS=1
    look(1, 0, mk(24'h5A5, 5), "R5");
    look(1, 1, mk(24'h5A5, 5), "R5");

    fill(1, 0, mk(24'h222, 2), "R7");
    fill(0, 0, mk(24'h222, 2), "R7");              // same tag, now non-secure
    look(1, 0, mk(24'h222, 2), "R7");
    look(0, 0, mk(24'h222, 2), "R7");
    fill(1, 0, mk(24'h333, 2), "R7");
    look(0, 0, mk(24'h222, 2), "R7");

    en_n = 0;                                      // R6
    look(0, 0, mk(24'h100 + 24'd7, 7), "R6");
    fill(0, 0, mk(24'hDDD, 7), "R6");
    look(1, 1, mk(24'h100 + 24'd7, 7), "R6");
    en_n = 1;
    look(0, 0, mk(24'h100 + 24'd7, 7), "R6");
    look(0, 0, mk(24'hDDD, 7), "R6");
    en_s = 0;
    look(1, 0, mk(24'h100 + 24'd8, 8), "R6");
    fill(1, 0, mk(24'hEEE, 8), "R6");
    en_s = 1;
    look(1, 0, mk(24'h100 + 24'd8, 8), "R6");

    // R11: lookup and allocate of the same address in one cycle
    cyc(1, 1, 0, mk(24'h444, 9), 1, 1, 0, mk(24'h444, 9), 0, 0, 0, "R11");
    look(1, 0, mk(24'h444, 9), "R11");

    cyc(0, 0, 0, 32'h0, 0, 0, 0, 32'h0, 1, 1, 0, "R9");  // clear NS=0 lines
    sweep(24'h100, "R9");
    look(0, 0, mk(24'hABC, 3), "R9");

    // R11 and R8: global invalidate together with an allocate
    cyc(1, 0, 1, mk(24'h100 + 24'd1, 1), 1, 0, 1, mk(24'h999, 4), 1, 0, 0, "R11");
    look(0, 0, mk(24'h999, 4), "R11");
    sweep(24'h100, "R8");
    cyc(0, 0, 0, 32'h0, 0, 0, 0, 32'h0, 1, 0, 0, "R8");
    look(0, 0, mk(24'h999, 4), "R8");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule